// File: doc/BRIEF.md
# 128-bit Packed Shift Unit

This execution unit shifts a 128-bit packed operand in one of six ways, chosen by a 3-bit operation code. Two operations move the whole register by a count of bytes. Two operations shift each 64-bit lane by a count of bits, with no carry between lanes. Two more operations give a true bitwise shift of the full 128-bit value across the lane boundary. These are built from the lane shifters, a lane mask and a fixed half-register byte move.

The shift datapath is combinational. A single output register captures its result when the input strobe is high, so the latency is one cycle. The valid flag follows the strobe one cycle later.

Top module: `vshift_unit`

## Requirements
- R1: With op code 0 (byte left), for a count of 0 to 15 the result is the source moved left by count×8 bits, and the vacated low bytes are zero.
- R2: With op code 1 (byte right), for a count of 0 to 15 the result is the source moved right by count×8 bits, and the vacated high bytes are zero. A count of 8 places the upper 8 bytes in the lower 8 bytes and clears the upper half.
- R3: With op code 0 or 1, a count of 16 or more gives an all-zero result.
- R4: With op code 2 (lane left) or 3 (lane right), bits [63:0] and bits [127:64] are each shifted by the count on their own, and no bit crosses from one lane into the other.
- R5: With op code 2 or 3, a count of 64 or more gives zero in both lanes.
- R6: With op code 4 (wide left), for a count of 1 to 63 the result equals the 128-bit source shifted left by count bits, with bits carried from lane 0 into lane 1.
- R7: With op code 5 (wide right), for a count of 1 to 63 the result equals the 128-bit source shifted right by count bits, with bits carried from lane 1 into the top of lane 0.
- R8: With op code 4 or 5, a count of 0 passes the source through unchanged. A count of 64 to 127 moves one lane into the other by count−64 bits and zeroes the vacated lane. A count of 128 or more gives zero.
- R9: With op code 4 or 5, a count that is a multiple of 8 and below 128 gives the same result as the byte shift in the same direction by count/8.
- R10: `out_valid` equals `in_valid` of the previous cycle. `out_data` loads the new result one cycle after a strobe and holds its value when there is no strobe.
- R11: While `rst_n` is low at a clock edge, `out_data` and `out_valid` are cleared after that edge.
- R12: Op codes 6 and 7 are reserved and give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Operation code (0..5; 6 and 7 are reserved) |
| in_count | input | 8 | Shift count: bytes for op codes 0 and 1, bits otherwise |
| in_src | input | 128 | Source operand |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_data | output | 128 | Registered result |

## Verification
The bench aims at the count boundaries where a wrong design leaks data.

- **Byte shifts, counts 15 and 16:** a design that wraps the count would return a rotated or shifted value instead of zero at 16.
- **Lane shifts, counts 63 and 64:** a missing limit check would keep stale bits in a lane.
- **Wide shifts, counts 0, 63, 64, 127 and 128:** a wrong mask or spill amount would corrupt the bits that cross between the lanes. A wrong far-range decode would drop or double the moved lane.
- **Byte-equivalence cases:** these expose any disagreement between the wide path and the byte path.
- **Idle cycles after a strobe:** these show whether the output register wrongly reloads without a strobe.

// File: rtl/vshift_pkg.sv
`timescale 1ns/1ps
// Package: shared operation encoding for the packed shift unit.
// Assumes a 3-bit operation code; codes 6 and 7 are reserved.
package vshift_pkg;
    typedef enum logic [2:0] {
        OP_BYTE_L = 3'd0,
        OP_BYTE_R = 3'd1,
        OP_LANE_L = 3'd2,
        OP_LANE_R = 3'd3,
        OP_WIDE_L = 3'd4,
        OP_WIDE_R = 3'd5,
        OP_RSV6   = 3'd6,
        OP_RSV7   = 3'd7
    } vshift_op_e;
endpackage

// File: rtl/vshift_byte.sv
`timescale 1ns/1ps
// Module: whole-register byte shifter.
// Moves the full DATA_W vector by cnt bytes, left or right, and fills with zero.
// Assumes DATA_W is a multiple of 8. Any count of DATA_W/8 or more gives zero.
module vshift_byte #(
    parameter int DATA_W = 128,
    parameter int CNT_W  = 8
) (
    input  logic [DATA_W-1:0] src,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              dir_right,
    output logic [DATA_W-1:0] res
);
    localparam int              NUM_BYTES = DATA_W / 8;
    localparam logic [CNT_W-1:0] BYTE_LIM  = CNT_W'(NUM_BYTES);

    logic [CNT_W+2:0] bit_amt;

    // Convert the byte count to a bit amount.
    always_comb bit_amt = {cnt, 3'b000};

    // Select the direction and force zero when the count is out of range.
    always_comb begin
        if (cnt >= BYTE_LIM) begin
            res = '0;
        end else if (dir_right) begin
            res = src >> bit_amt;
        end else begin
            res = src << bit_amt;
        end
    end
endmodule

// File: rtl/vshift_lane.sv
`timescale 1ns/1ps
// Module: per-lane bit shifter.
// Shifts each LANE_W-bit lane by cnt bits on its own, with no carry between lanes.
// Assumes DATA_W = NUM_LANES * LANE_W. A count of LANE_W or more zeroes every lane.
module vshift_lane #(
    parameter int LANE_W    = 64,
    parameter int NUM_LANES = 2,
    parameter int CNT_W     = 8,
    localparam int DATA_W   = LANE_W * NUM_LANES
) (
    input  logic [DATA_W-1:0] src,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              dir_right,
    output logic [DATA_W-1:0] res
);
    localparam logic [CNT_W-1:0] LANE_LIM = CNT_W'(LANE_W);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_in;
        logic [LANE_W-1:0] lane_out;

        // Extract this lane from the packed source.
        always_comb lane_in = src[g*LANE_W +: LANE_W];

        // Shift this lane alone and clear it when the count is out of range.
        always_comb begin
            if (cnt >= LANE_LIM) begin
                lane_out = '0;
            end else if (dir_right) begin
                lane_out = lane_in >> cnt;
            end else begin
                lane_out = lane_in << cnt;
            end
        end

        // Place this lane back into the packed result.
        always_comb res[g*LANE_W +: LANE_W] = lane_out;
    end
endmodule

// File: rtl/vshift_wide.sv
`timescale 1ns/1ps
// Module: cross-lane bitwise shifter for a two-lane operand.
// Near range (1..LANE_W-1):
//   - shifts each lane by cnt;
//   - shifts a copy of each lane the other way by LANE_W-cnt;
//   - masks that copy to cnt bits;
//   - moves it by half a register with a byte move;
//   - ORs the two parts.
// Far range (LANE_W..2*LANE_W-1): moves one lane into the other.
// A count of 0 passes the source through; 2*LANE_W or more gives zero.
// Assumes exactly two lanes and that LANE_W is a multiple of 8.
module vshift_wide #(
    parameter int LANE_W   = 64,
    parameter int CNT_W    = 8,
    localparam int DATA_W  = 2 * LANE_W
) (
    input  logic [DATA_W-1:0] src,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              dir_right,
    output logic [DATA_W-1:0] res
);
    localparam logic [CNT_W-1:0] LANE_AMT = CNT_W'(LANE_W);
    localparam logic [CNT_W-1:0] MOVE_CNT = CNT_W'(LANE_W / 8);
    localparam logic [CNT_W:0]   WIDE_LIM = (CNT_W+1)'(DATA_W);

    logic [CNT_W-1:0]  inv_cnt;
    logic [CNT_W-1:0]  far_cnt;
    logic [DATA_W-1:0] main_v;
    logic [DATA_W-1:0] spill_raw;
    logic [LANE_W-1:0] keep_mask;
    logic [DATA_W-1:0] spill_m;
    logic [DATA_W-1:0] moved;
    logic [LANE_W-1:0] lo_lane;
    logic [LANE_W-1:0] hi_lane;

    // Derive the spill amount and the far-range amount from the count.
    always_comb begin
        inv_cnt = LANE_AMT - cnt;
        far_cnt = cnt - LANE_AMT;
    end

    // Split the source into its two lanes.
    always_comb begin
        lo_lane = src[LANE_W-1:0];
        hi_lane = src[DATA_W-1:LANE_W];
    end

    // Shift each lane in the requested direction.
    vshift_lane #(.LANE_W(LANE_W), .NUM_LANES(2), .CNT_W(CNT_W)) u_main (
        .src       (src),
        .cnt       (cnt),
        .dir_right (dir_right),
        .res       (main_v)
    );

    // Shift a copy of each lane the opposite way, so its outgoing bits line up with the other lane.
    vshift_lane #(.LANE_W(LANE_W), .NUM_LANES(2), .CNT_W(CNT_W)) u_spill (
        .src       (src),
        .cnt       (inv_cnt),
        .dir_right (!dir_right),
        .res       (spill_raw)
    );

    // Build the mask: low cnt bits for a left shift, high cnt bits for a right shift.
    always_comb begin
        if (dir_right) begin
            keep_mask = ~({LANE_W{1'b1}} >> cnt);
        end else begin
            keep_mask = ~({LANE_W{1'b1}} << cnt);
        end
    end

    // Apply the mask to both lanes of the spilled copy.
    always_comb spill_m = spill_raw & {keep_mask, keep_mask};

    // Move the spilled bits across the lane boundary by half a register.
    vshift_byte #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_move (
        .src       (spill_m),
        .cnt       (MOVE_CNT),
        .dir_right (dir_right),
        .res       (moved)
    );

    // Pick the result for the count range.
    always_comb begin
        if (cnt == '0) begin
            res = src;
        end else if (cnt < LANE_AMT) begin
            res = main_v | moved;
        end else if ({1'b0, cnt} < WIDE_LIM) begin
            if (dir_right) begin
                res = {{LANE_W{1'b0}}, hi_lane >> far_cnt};
            end else begin
                res = {lo_lane << far_cnt, {LANE_W{1'b0}}};
            end
        end else begin
            res = '0;
        end
    end
endmodule

// File: rtl/vshift_unit.sv
`timescale 1ns/1ps
// Module: top of the 128-bit packed shift unit.
// Decodes the operation and selects among the byte, lane and wide shifters.
// Registers the result with a one-cycle latency.
// Assumes a synchronous active-low reset. The result register loads only on a strobe.
module vshift_unit #(
    parameter int LANE_W   = 64,
    parameter int CNT_W    = 8,
    localparam int DATA_W  = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic [CNT_W-1:0]  in_count,
    input  logic [DATA_W-1:0] in_src,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    import vshift_pkg::*;

    vshift_op_e        op;
    logic              dir_right;
    logic [DATA_W-1:0] byte_res;
    logic [DATA_W-1:0] lane_res;
    logic [DATA_W-1:0] wide_res;
    logic [DATA_W-1:0] next_res;

    // Decode the operation code and the shift direction.
    always_comb begin
        op        = vshift_op_e'(in_op);
        dir_right = (op == OP_BYTE_R) || (op == OP_LANE_R) || (op == OP_WIDE_R);
    end

    // Whole-register byte shifter.
    vshift_byte #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_byte (
        .src       (in_src),
        .cnt       (in_count),
        .dir_right (dir_right),
        .res       (byte_res)
    );

    // Independent per-lane bit shifter.
    vshift_lane #(.LANE_W(LANE_W), .NUM_LANES(2), .CNT_W(CNT_W)) u_lane (
        .src       (in_src),
        .cnt       (in_count),
        .dir_right (dir_right),
        .res       (lane_res)
    );

    // Cross-lane bitwise shifter.
    vshift_wide #(.LANE_W(LANE_W), .CNT_W(CNT_W)) u_wide (
        .src       (in_src),
        .cnt       (in_count),
        .dir_right (dir_right),
        .res       (wide_res)
    );

    // Select the result for the operation; reserved codes give zero.
    always_comb begin
        unique case (op)
            OP_BYTE_L, OP_BYTE_R: next_res = byte_res;
            OP_LANE_L, OP_LANE_R: next_res = lane_res;
            OP_WIDE_L, OP_WIDE_R: next_res = wide_res;
            default:              next_res = '0;
        endcase
    end

    // Output register: clears on reset and loads on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= next_res;
            end
        end
    end
endmodule

// File: rtl/vshift_checker.sv
`timescale 1ns/1ps
// Module: assertion checker for vshift_unit, attached with bind.
// Checks timing, hold, reset and out-of-range behaviour at the ports.
module vshift_checker #(
    parameter int LANE_W   = 64,
    parameter int CNT_W    = 8,
    localparam int DATA_W  = 2 * LANE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        in_op,
    input logic [CNT_W-1:0]  in_count,
    input logic [DATA_W-1:0] in_src,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    localparam logic [CNT_W-1:0] BYTE_LIM = CNT_W'(DATA_W / 8);
    localparam logic [CNT_W-1:0] LANE_LIM = CNT_W'(LANE_W);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R10
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data)); // R10
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (out_data == '0 && !out_valid)); // R11
    AST_BYTE_OVERRANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[2:1] == 2'b00 && in_count >= BYTE_LIM) |=> out_data == '0); // R3
    AST_LANE_OVERRANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[2:1] == 2'b01 && in_count >= LANE_LIM) |=> out_data == '0); // R5
    AST_WIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[2:1] == 2'b10 && in_count == '0) |=> out_data == $past(in_src)); // R8
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[2:1] == 2'b11) |=> out_data == '0); // R12
endmodule

bind vshift_unit vshift_checker #(.LANE_W(LANE_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_count  (in_count),
    .in_src    (in_src),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/test_vshift_unit.sv
`timescale 1ns/1ps
// Bench for vshift_unit: directed corner cases plus seeded random stimulus,
// checked against reference functions written from the requirements.
module test_vshift_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [2:0]   in_op = '0;
    logic [7:0]   in_count = '0;
    logic [127:0] in_src = '0;
    logic         out_valid;
    logic [127:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    vshift_unit i_vshift_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_op     (in_op),
        .in_count  (in_count),
        .in_src    (in_src),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // Reference model written from the requirements.
    function automatic logic [127:0] ref_model(input logic [2:0] op, input int cnt, input logic [127:0] s);
        logic [63:0] lo = s[63:0];
        logic [63:0] hi = s[127:64];
        case (op)
            3'd0: return (cnt > 15) ? '0 : s << (cnt * 8);
            3'd1: return (cnt > 15) ? '0 : s >> (cnt * 8);
            3'd2: return (cnt >= 64) ? '0 : {hi << cnt, lo << cnt};
            3'd3: return (cnt >= 64) ? '0 : {hi >> cnt, lo >> cnt};
            3'd4: return (cnt >= 128) ? '0 : s << cnt;
            3'd5: return (cnt >= 128) ? '0 : s >> cnt;
            default: return '0;
        endcase
    endfunction

    // Names the requirement an operation and count exercise.
    function automatic string req_tag(input logic [2:0] op, input int cnt);
        case (op)
            3'd0: return (cnt > 15) ? "R3" : "R1";
            3'd1: return (cnt > 15) ? "R3" : "R2";
            3'd2, 3'd3: return (cnt >= 64) ? "R5" : "R4";
            3'd4: return (cnt == 0 || cnt >= 64) ? "R8" : "R6";
            3'd5: return (cnt == 0 || cnt >= 64) ? "R8" : "R7";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %032h expected %032h", tag, got, exp);
        end
    endtask

    // Apply one operation and check the result and valid one cycle later.
    task automatic run_op(input logic [2:0] op, input int cnt, input logic [127:0] s,
                          input logic [127:0] exp, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        in_count = 8'(cnt);
        in_src   = s;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, out_data, exp);
        check("R10", {127'd0, out_valid}, 128'd1);
    endtask

    task automatic run_ref(input logic [2:0] op, input int cnt, input logic [127:0] s);
        run_op(op, cnt, s, ref_model(op, cnt, s), req_tag(op, cnt));
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    // Watchdog: count an expired run as a failure and still print the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [127:0] pat;
        logic [127:0] held;
        void'($urandom(32'd20020927));
        pat = 128'h0123456789ABCDEF_FEDCBA9876543210;

        // R11: reset clears the outputs, even with a strobe present.
        in_valid = 1'b1;
        in_op    = 3'd4;
        in_src   = pat;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11", out_data, '0);
        check("R11", {127'd0, out_valid}, '0);
        in_valid = 1'b0;
        rst_n    = 1'b1;

        // Byte shifts at the range boundary.
        run_op(3'd1, 8, pat, {64'd0, pat[127:64]}, "R2");
        run_op(3'd0, 15, pat, {pat[7:0], 120'd0}, "R1");
        run_op(3'd0, 16, pat, '0, "R3");
        run_op(3'd1, 200, pat, '0, "R3");

        // Lane shifts: no carry between lanes, zero at 64.
        run_op(3'd2, 4, {64'h0, 64'hF000000000000001}, {64'h0, 64'h0000000000000010}, "R4");
        run_op(3'd3, 4, {64'h000000000000000F, 64'h0}, {64'h0, 64'h0}, "R4");
        run_op(3'd2, 63, pat, {pat[64], 63'd0, pat[0], 63'd0}, "R4");
        run_op(3'd3, 64, pat, '0, "R5");

        // Wide shifts: carries across the lane boundary and all count ranges.
        run_op(3'd4, 1, {64'h0, 64'h8000000000000000}, {64'h1, 64'h0}, "R6");
        run_op(3'd5, 1, {64'h1, 64'h0}, {64'h0, 64'h8000000000000000}, "R7");
        run_ref(3'd4, 63, pat);
        run_ref(3'd5, 63, pat);
        run_op(3'd4, 0, pat, pat, "R8");
        run_op(3'd5, 0, pat, pat, "R8");
        run_op(3'd4, 64, pat, {pat[63:0], 64'd0}, "R8");
        run_op(3'd5, 100, pat, {64'd0, 28'd0, pat[127:100]}, "R8");
        run_ref(3'd4, 127, pat);
        run_op(3'd5, 128, pat, '0, "R8");
        run_op(3'd4, 255, pat, '0, "R8");

        // R9: wide shifts by multiples of 8 match the byte shift.
        for (int k = 0; k < 16; k++) begin
            logic [127:0] s = rnd128();
            run_op(3'd4, k * 8, s, ref_model(3'd0, k, s), "R9");
            run_op(3'd5, k * 8, s, ref_model(3'd1, k, s), "R9");
        end

        // R12: reserved op codes give zero.
        run_op(3'd6, 3, pat, '0, "R12");
        run_op(3'd7, 0, pat, '0, "R12");

        // R10: with no strobe, the output holds and valid stays low.
        run_ref(3'd4, 5, pat);
        held = out_data;
        @(negedge clk);
        in_op    = 3'd1;
        in_count = 8'd2;
        in_src   = ~pat;
        repeat (3) @(negedge clk);
        check("R10", out_data, held);
        check("R10", {127'd0, out_valid}, '0);

        // Random mix: counts biased toward the interesting ranges.
        for (int i = 0; i < 600; i++) begin
            logic [2:0] op = 3'($urandom_range(0, 7));
            int cnt;
            case ($urandom_range(0, 3))
                0: cnt = $urandom_range(0, 17);
                1: cnt = $urandom_range(0, 66);
                2: cnt = $urandom_range(60, 130);
                default: cnt = $urandom_range(0, 255);
            endcase
            run_ref(op, cnt, rnd128());
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule